// File: doc/BRIEF.md
# Receive Checksum Accumulator

This block watches the receive byte stream of an Ethernet MAC and forms a raw 16-bit ones'-complement sum over each frame. The sum begins at a programmable half-word position and runs to the last byte of the frame. Bytes are paired big-endian, so the byte at an even distance from the start position is the high byte of a word. The end-around carry is folded on every addition.

One cycle after the last byte of a frame, the block presents a status word with a single-cycle valid strobe. The status word holds the uncomplemented sum and the frame length in bytes. Software complements the sum. Software also corrects for IP-option words and applies any protocol checks, so the hardware skips nothing beyond the fixed start position.

The start position comes from a 7-bit field of a configuration word and is counted in 16-bit half-words. A typical value is 17: a 14-byte Ethernet header plus a 20-byte base IP header, divided by two. The block samples the field on the first byte of each frame.

Top module: `rx_csum_accum`

## Requirements
- R1: The start position is read from bits 22:16 of `cfg_word`, in half-word units. Frame bytes at index below twice that value (byte 0 is the start-of-frame byte) are excluded from the sum. All other bits of `cfg_word` have no effect.
- R2: From the start position on, the byte at an even index is added as the high byte (bits 15:8) of a 16-bit word, and the byte at an odd index as the low byte (bits 7:0).
- R3: When a frame ends on an even index, its last byte counts as a word whose high byte is that byte and whose low byte is zero.
- R4: Each carry out of bit 15 is added back into bit 0, so the reported sum is always a folded 16-bit ones'-complement value.
- R5: A frame whose length is at most twice the start value reports a sum of 0x0000, together with the correct length.
- R6: The status word carries the sum in bits 15:0, the frame length in bytes in bits 29:16, and zeros in bits 31:30. `stat_valid` is high for exactly one cycle, in the cycle after the end-of-frame byte is accepted, and is low out of reset.
- R7: The sum is cleared at each start-of-frame byte, so nothing carries over from one frame into the next.
- R8: A change of `cfg_word` after the start-of-frame byte does not affect that frame. The frame uses the value present with its start-of-frame byte.
- R9: Cycles with `in_valid` low neither advance the byte position nor change the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is present on `in_byte` |
| in_byte | input | 8 | Received byte |
| in_sof | input | 1 | Current byte is the first of a frame |
| in_eof | input | 1 | Current byte is the last of a frame |
| cfg_word | input | 32 | Receive configuration; start half-word in bits 22:16 |
| stat_valid | output | 1 | One-cycle strobe for `stat_word` |
| stat_word | output | 32 | {2'b00, length[13:0], raw sum[15:0]} |

## Verification
The bench checks three places where an off-by-one error would show:
- A frame exactly as long as the start window must report zero. A design comparing with the wrong inequality would add one stray byte.
- An odd-length frame must place its last byte high. Swapping the pairing would return a byte-swapped sum.
- A byte sequence that overflows bit 15 must show the folded carry. Dropping the fold would make the sum one too small.

A start value rewritten in the middle of a frame must leave that frame untouched; a design reading the field live would move its window. Back-to-back frames and idle gaps expose a sum that is not cleared or a position that advances on idle cycles.

// File: rtl/rxc_pkg.sv
// Package: shared widths and the status word layout of the receive
// checksum accumulator. Assumes a 16-bit ones'-complement sum.
package rxc_pkg;
    localparam int SUM_W = 16;
    localparam int LEN_W = 14;
    localparam int OFS_W = 7;
    localparam int OFS_LSB = 16;

    typedef struct packed {
        logic [1:0]       rsvd;
        logic [LEN_W-1:0] len;
        logic [SUM_W-1:0] sum;
    } rxc_stat_t;

    // Adds two 16-bit values and folds the end-around carry back in.
    function automatic logic [SUM_W-1:0] oc_add(input logic [SUM_W-1:0] a,
                                                input logic [SUM_W-1:0] b);
        logic [SUM_W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, t[SUM_W]};
    endfunction
endpackage

// File: rtl/rxc_offset_latch.sv
// Offset latch: takes the start half-word field from the configuration word
// on each start-of-frame byte and holds it for the rest of the frame.
// Assumes the field sits at OFS_LSB with OFS_W bits.
module rxc_offset_latch #(
    parameter int OFS_W   = 7,
    parameter int OFS_LSB = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             sof,
    input  logic [31:0]      cfg_word,
    output logic [OFS_W-1:0] ofs_eff
);
    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] field;

    // Extract the start field from the live configuration word.
    always_comb field = cfg_word[OFS_LSB +: OFS_W];

    // Use the live field on the first byte, the held value after it.
    always_comb ofs_eff = (take && sof) ? field : ofs_q;

    // Capture the field at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)            ofs_q <= '0;
        else if (take && sof)  ofs_q <= field;
    end

    AST_OFS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && sof) |=> $stable(ofs_q)); // R8
endmodule

// File: rtl/rxc_byte_tracker.sv
// Byte tracker: keeps the byte position inside the current frame, decides
// whether the current byte lies inside the summing window and which half
// of a word it fills. Assumes the start position is even in bytes.
module rxc_byte_tracker #(
    parameter int LEN_W = 14,
    parameter int OFS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [OFS_W-1:0] ofs_eff,
    output logic             take,
    output logic             in_win,
    output logic             hi_half,
    output logic [LEN_W-1:0] len_now
);
    localparam int START_W = OFS_W + 1;

    logic [LEN_W-1:0]   cnt_q;
    logic [LEN_W-1:0]   idx;
    logic [START_W-1:0] start_byte;
    logic               frame_q;

    // Accept a byte on a frame start or inside an open frame.
    always_comb take = in_valid && (in_sof || frame_q);

    // Position of the current byte; zero on the start-of-frame byte.
    always_comb idx = in_sof ? '0 : cnt_q;

    // Window and half selection for the current byte.
    always_comb begin
        start_byte = {ofs_eff, 1'b0};
        in_win     = take && (idx >= LEN_W'(start_byte));
        hi_half    = ~idx[0];
        len_now    = idx + 1'b1;
    end

    // Advance the byte position on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (take) cnt_q <= len_now;
    end

    // Track whether a frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n)    frame_q <= 1'b0;
        else if (take) frame_q <= !in_eof;
    end

    AST_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/rxc_ones_acc.sv
// Ones'-complement accumulator: adds each windowed byte into the running
// sum at its half-word position and folds the carry on every addition.
// Clears on the start-of-frame byte.
module rxc_ones_acc
    import rxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             sof,
    input  logic             in_win,
    input  logic             hi_half,
    input  logic [7:0]       byte_in,
    output logic [SUM_W-1:0] acc_next
);
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] addend;

    // Place the byte in the high or the low half of a word.
    always_comb addend = hi_half ? {byte_in, 8'h00} : {8'h00, byte_in};

    // Next sum: restart at frame start, add only inside the window.
    always_comb begin
        base = sof ? '0 : acc_q;
        if (!take)       acc_next = acc_q;
        else if (in_win) acc_next = oc_add(base, addend);
        else             acc_next = base;
    end

    // Hold the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_next;
    end

    AST_SUM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sof && !in_win) |=> (acc_q == '0)); // R7
    AST_SUM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(acc_q)); // R9
endmodule

// File: rtl/rx_csum_accum.sv
// Receive checksum accumulator top: ties the offset latch, byte tracker
// and accumulator together. Registers the status word one cycle after the
// end-of-frame byte. Assumes frames of at most 2**LEN_W-1 bytes.
module rx_csum_accum
    import rxc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [31:0] cfg_word,
    output logic        stat_valid,
    output logic [31:0] stat_word
);
    logic [OFS_W-1:0] ofs_eff;
    logic             take;
    logic             in_win;
    logic             hi_half;
    logic [LEN_W-1:0] len_now;
    logic [SUM_W-1:0] acc_next;
    rxc_stat_t        stat_q;

    rxc_offset_latch #(.OFS_W(OFS_W), .OFS_LSB(OFS_LSB)) u_ofs (
        .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof),
        .cfg_word(cfg_word), .ofs_eff(ofs_eff));

    rxc_byte_tracker #(.LEN_W(LEN_W), .OFS_W(OFS_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .ofs_eff(ofs_eff), .take(take), .in_win(in_win),
        .hi_half(hi_half), .len_now(len_now));

    rxc_ones_acc u_acc (
        .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof),
        .in_win(in_win), .hi_half(hi_half), .byte_in(in_byte),
        .acc_next(acc_next));

    // Register the status word and its strobe after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_q     <= '0;
        end else begin
            stat_valid <= take && in_eof;
            if (take && in_eof) begin
                stat_q.rsvd <= 2'b00;
                stat_q.len  <= len_now;
                stat_q.sum  <= acc_next;
            end
        end
    end

    always_comb stat_word = stat_q;

    AST_STAT_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(in_valid && in_eof)); // R6
    AST_STAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid || $past(in_valid && in_eof)); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_word[31:30] == 2'b00)); // R6
    AST_ONE_BYTE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && $past(in_valid && in_sof && in_eof))
            |-> (stat_word[29:16] == 14'd1)); // R6
endmodule

// File: tb/tb_rx_csum_accum.sv
// Directed bench for the receive checksum accumulator.
module tb_rx_csum_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        stat_valid;
    logic [31:0] stat_word;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] fb [0:255];

    always #2.5 clk = ~clk;

    rx_csum_accum dut (.*);

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference sum from the requirements: full-width total, folded at the end.
    function automatic logic [15:0] ref_sum(input int len, input int ofs);
        logic [31:0] t = 0;
        for (int i = 2 * ofs; i < len; i++)
            t += (i % 2 == 0) ? {16'd0, fb[i], 8'd0} : {24'd0, fb[i]};
        while (t[31:16] != 0) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
        return t[15:0];
    endfunction

    // Drive one frame from fb; optional mid-frame config change and idle gaps.
    task automatic send_frame(input int len, input int ofs, input bit midchg,
                              input int gap, input logic [15:0] exp_sum,
                              input string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) cfg_word = 32'hA5000_0F3 & ~32'h007F_0000 | (32'(ofs) << 16);
            if (i == 1 && midchg) cfg_word = 32'h0000_0000;
            in_valid = 1'b1; in_byte = fb[i];
            in_sof = (i == 0); in_eof = (i == len - 1);
            check(req, {31'd0, stat_valid}, 32'd0);
            if (gap > 0 && i != len - 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
                in_byte = 8'hEE;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        check({req, " valid"}, {31'd0, stat_valid}, 32'd1);
        check({req, " word"}, stat_word, {2'b00, 14'(len), exp_sum});
        @(negedge clk);
        check({req, " pulse"}, {31'd0, stat_valid}, 32'd0);
    endtask

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) fb[i] = 8'((i * 37 + seed * 11) ^ (i >> 2));
    endtask

    task automatic t_reset();
        check("R6 reset valid", {31'd0, stat_valid}, 32'd0);
        check("R6 reset word", stat_word, 32'd0);
    endtask

    task automatic t_known();
        fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'h56;
        send_frame(3, 0, 1'b0, 0, 16'h6834, "R2 R3 known");
        fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'h00; fb[3] = 8'h01;
        send_frame(4, 0, 1'b0, 0, 16'h0001, "R4 carry");
        fb[0] = 8'h9C;
        send_frame(1, 0, 1'b0, 0, 16'h9C00, "R3 R6 one byte");
    endtask

    task automatic t_typical();
        fill(60, 1);
        send_frame(60, 17, 1'b0, 0, ref_sum(60, 17), "R1 R2 ofs17 even");
        fill(61, 2);
        send_frame(61, 17, 1'b0, 0, ref_sum(61, 17), "R1 R3 ofs17 odd");
        fill(40, 3);
        send_frame(40, 5, 1'b0, 0, ref_sum(40, 5), "R1 ofs5");
    endtask

    task automatic t_carry();
        for (int i = 0; i < 100; i++) fb[i] = 8'hFF;
        send_frame(100, 0, 1'b0, 0, 16'hFFFF, "R4 all ones");
        for (int i = 0; i < 90; i++) fb[i] = 8'hF7;
        send_frame(90, 2, 1'b0, 0, ref_sum(90, 2), "R4 heavy carry");
    endtask

    task automatic t_short();
        fill(20, 4);
        send_frame(20, 17, 1'b0, 0, 16'h0000, "R5 short");
        fill(34, 5);
        send_frame(34, 17, 1'b0, 0, 16'h0000, "R5 exact window");
        fill(35, 6);
        send_frame(35, 17, 1'b0, 0, {fb[34], 8'h00}, "R5 R1 one past");
    endtask

    task automatic t_backtoback();
        for (int i = 0; i < 50; i++) fb[i] = 8'hC3;
        send_frame(50, 0, 1'b0, 0, ref_sum(50, 0), "R7 first");
        fill(44, 7);
        send_frame(44, 17, 1'b0, 0, ref_sum(44, 17), "R7 second");
    endtask

    task automatic t_midcfg();
        fill(64, 8);
        send_frame(64, 17, 1'b1, 0, ref_sum(64, 17), "R8 mid change");
    endtask

    task automatic t_gaps();
        fill(47, 9);
        send_frame(47, 3, 1'b0, 2, ref_sum(47, 3), "R9 gaps");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known();
        t_typical();
        t_carry();
        t_short();
        t_backtoback();
        t_midcfg();
        t_gaps();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule